// File: doc/BRIEF.md
# Two-Level Interrupt Control Register

This block is the interrupt control register of a small microcontroller core. It is one byte on the CPU bus and holds three kinds of bit. A master enable opens or closes every request. A group enable gates the requests that other peripherals raise outside this register. Three local enables each pair with a sticky event flag, for timer wrap, a rising edge on an external pin, and a change on a general-purpose port. A second bus address holds a per-pin mask. The mask chooses which port pins can raise the port-change flag.

The block contains its own event front ends. The external pin passes through a two-flop synchroniser and a rising-edge detector. The port pins are synchronised and compared every cycle against the values sampled one cycle before. A flag latches whether or not its enable bits are set. Hardware never clears a flag. Only a bus write of 0 clears it, and when a hardware event and a clearing write land in the same cycle, the event wins. The single `irq` output combines the enabled flags, the gated peripheral requests and the master enable.

Reads return data on a valid-only response channel. `bus_rvalid` pulses one cycle after `bus_rd`. There is no ready signal, so the bus master must take the data in that cycle. Writes complete in the cycle they are presented. The event strobes and pins are plain level or pulse inputs.

Top module: `irq_ctl`

## Requirements
- R1: After reset the control byte reads 0, except bit 0, which takes the value of `cflag_init`. The change mask reads 0.
- R2: The control byte at address 0 is laid out as follows:
  - bit 7: master enable
  - bit 6: group enable
  - bit 5: timer-wrap enable
  - bit 4: pin-edge enable
  - bit 3: port-change enable
  - bit 2: timer-wrap flag
  - bit 1: pin-edge flag
  - bit 0: port-change flag

  A write at address 0 stores all eight bits, and a read returns them.
- R3: A one-cycle pulse on `tmr_wrap` sets bit 2, whatever the state of any enable bit.
- R4: A 0-to-1 transition on `ext_pin` sets bit 1 within four cycles, whatever the state of any enable bit. A 1-to-0 transition leaves bit 1 unchanged.
- R5: A change on port pin i sets bit 0 only if bit i of the change mask (address 1, low NPINS bits) is 1. A change on a pin whose mask bit is 0 leaves bit 0 unchanged.
- R6: The flags are sticky: they hold until a bus write puts 0 in them.
- R7: If a flag's hardware set event and a bus write of 0 to that flag occur in the same cycle, the flag ends up 1.
- R8: `irq` is 1 exactly when bit 7 is 1 and at least one pair of enable and flag (bits 5/2, 4/1, 3/0) is 1/1, or the peripheral term of R9 is 1. With bit 7 at 0, `irq` is 0.
- R9: The peripheral term is 1 when bit 6 is 1 and any bit of `periph_req` is 1. It reaches `irq` only through bit 7.
- R10: `bus_rvalid` is 1 for exactly the cycle after a cycle with `bus_rd` at 1. In that cycle `bus_rdata` holds the register selected by `bus_addr` as it stood in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the control byte, 1 selects the change mask |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid, no back-pressure |
| tmr_wrap | input | 1 | Pulse when the timer wraps from its maximum count to zero |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | NPINS | Asynchronous port pin levels |
| periph_req | input | NPERIPH | Peripheral-group request levels |
| cflag_init | input | 1 | Reset value of the port-change flag |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with NPINS at 6 and NPERIPH at 3. A six-bit mask leaves the top two mask bits unused, so the zero-extended mask read is exercised. Three request lines let the group gate be tested with a request on a line other than line 0. These values still let the bench toggle both a masked and an unmasked port pin, and raise a timer strobe in the same cycle as a clearing write.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int CTRL_W  = 8;
  localparam int B_MEN   = 7;
  localparam int B_GEN   = 6;
  localparam int B_TEN   = 5;
  localparam int B_XEN   = 4;
  localparam int B_CEN   = 3;
  localparam int B_TFLG  = 2;
  localparam int B_XFLG  = 1;
  localparam int B_CFLG  = 0;

  typedef enum logic { SEL_CTRL = 1'b0, SEL_MASK = 1'b1 } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic pin_s;
  logic pin_prev;

  irq_sync #(.W(1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin),
    .q_sync  (pin_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_s;
  end

  assign rise = pin_s & ~pin_prev;

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             mask_we,
  input  logic [NPINS-1:0] mask_wdata,
  output logic [NPINS-1:0] mask_q,
  output logic             change
);
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] last_q;
  logic [NPINS-1:0] diff;

  irq_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins),
    .q_sync  (pins_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      mask_q <= '0;
    end else begin
      last_q <= pins_s;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_cmp
      assign diff[i] = (pins_s[i] ^ last_q[i]) & mask_q[i];
    end
  endgenerate

  assign change = |diff;

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !change);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              set_t,
  input  logic              set_x,
  input  logic              set_c,
  input  logic              cflag_init,
  output logic [CTRL_W-1:0] q
);
  logic [CTRL_W-1:0] sets;
  logic [CTRL_W-1:0] base;

  always_comb begin
    sets         = '0;
    sets[B_TFLG] = set_t;
    sets[B_XFLG] = set_x;
    sets[B_CFLG] = set_c;
    base         = we ? wdata : q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q         <= '0;
      q[B_CFLG] <= cflag_init;
    end else begin
      q <= base | sets;
    end
  end

  assert_tflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q[B_TFLG]) |-> $past(we && !wdata[B_TFLG]));
  assert_xflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q[B_XFLG]) |-> $past(we && !wdata[B_XFLG]));
  assert_cflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q[B_CFLG]) |-> $past(we && !wdata[B_CFLG]));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_t |=> q[B_TFLG]);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NPINS   = 8,
  parameter int NPERIPH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_addr,
  input  logic               bus_we,
  input  logic               bus_rd,
  input  logic [CTRL_W-1:0]  bus_wdata,
  output logic [CTRL_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic               tmr_wrap,
  input  logic               ext_pin,
  input  logic [NPINS-1:0]   port_pins,
  input  logic [NPERIPH-1:0] periph_req,
  input  logic               cflag_init,
  output logic               irq
);
  localparam int PAD = CTRL_W - NPINS;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NPINS-1:0]  mask_q;
  logic              pin_rise;
  logic              port_chg;
  logic              ctrl_we;
  logic              mask_we;
  logic [CTRL_W-1:0] rd_mux;
  logic              periph_term;
  logic              local_term;

  assign ctrl_we = bus_we && (reg_sel_e'(bus_addr) == SEL_CTRL);
  assign mask_we = bus_we && (reg_sel_e'(bus_addr) == SEL_MASK);

  irq_pin_edge u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_pin),
    .rise  (pin_rise)
  );

  irq_port_change #(.NPINS(NPINS)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins       (port_pins),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata[NPINS-1:0]),
    .mask_q     (mask_q),
    .change     (port_chg)
  );

  irq_ctl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (ctrl_we),
    .wdata      (bus_wdata),
    .set_t      (tmr_wrap),
    .set_x      (pin_rise),
    .set_c      (port_chg),
    .cflag_init (cflag_init),
    .q          (ctrl_q)
  );

  generate
    if (PAD > 0) begin : g_pad
      assign rd_mux = (reg_sel_e'(bus_addr) == SEL_MASK) ? {{PAD{1'b0}}, mask_q} : ctrl_q;
    end else begin : g_nopad
      assign rd_mux = (reg_sel_e'(bus_addr) == SEL_MASK) ? mask_q[CTRL_W-1:0] : ctrl_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign local_term  = (ctrl_q[B_TEN] & ctrl_q[B_TFLG]) |
                       (ctrl_q[B_XEN] & ctrl_q[B_XFLG]) |
                       (ctrl_q[B_CEN] & ctrl_q[B_CFLG]);
  assign periph_term = ctrl_q[B_GEN] & (|periph_req);
  assign irq         = ctrl_q[B_MEN] & (local_term | periph_term);

  assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_MEN] |-> !irq);
  assert_periph_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_MEN] && ctrl_q[B_GEN] && (|periph_req)) |-> irq);
  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));
  assert_rvalid_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/irq_ctl_bench.sv
module irq_ctl_bench;
  localparam int NPINS   = 6;
  localparam int NPERIPH = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_addr = 1'b0;
  logic               bus_we = 1'b0;
  logic               bus_rd = 1'b0;
  logic [7:0]         bus_wdata = '0;
  logic [7:0]         bus_rdata;
  logic               bus_rvalid;
  logic               tmr_wrap = 1'b0;
  logic               ext_pin = 1'b0;
  logic [NPINS-1:0]   port_pins = '0;
  logic [NPERIPH-1:0] periph_req = '0;
  logic               cflag_init = 1'b1;
  logic               irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  irq_ctl #(.NPINS(NPINS), .NPERIPH(NPERIPH)) u_irq_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmr_wrap(tmr_wrap), .ext_pin(ext_pin),
    .port_pins(port_pins), .periph_req(periph_req),
    .cflag_init(cflag_init), .irq(irq)
  );

  // monitor: pops expected read data whenever a response appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected read response %02h, expected none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          errors++;
          $display("FAIL %s: read %02h expected %02h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input logic a, input logic [7:0] d, input string tag);
    exp_t e;
    e.val = d; e.tag = tag;
    exp_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %0b expected %0b", tag, irq, e);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset values
    rd_expect(1'b0, 8'h01, "R1");
    rd_expect(1'b1, 8'h00, "R1");
    chk_irq(1'b0, "R1");
    wr(1'b0, 8'h00);
    // R2 layout: enables without master
    wr(1'b0, 8'h78);
    rd_expect(1'b0, 8'h78, "R2");
    chk_irq(1'b0, "R8");
    // R3 timer wrap with master off
    tmr_wrap = 1'b1; step(1); tmr_wrap = 1'b0;
    step(5);
    rd_expect(1'b0, 8'h7C, "R3");
    chk_irq(1'b0, "R8");
    // R8 master on with enabled timer flag
    wr(1'b0, 8'hFC);
    chk_irq(1'b1, "R8");
    // R6 software clear
    wr(1'b0, 8'hF8);
    chk_irq(1'b0, "R6");
    rd_expect(1'b0, 8'hF8, "R6");
    // R4 pin rising edge, local enable off
    wr(1'b0, 8'h80);
    ext_pin = 1'b1; step(5);
    rd_expect(1'b0, 8'h82, "R4");
    chk_irq(1'b0, "R8");
    wr(1'b0, 8'h80);
    ext_pin = 1'b0; step(5);
    rd_expect(1'b0, 8'h80, "R4");
    // R5 unmasked pin ignored
    port_pins[0] = 1'b1; step(5);
    rd_expect(1'b0, 8'h80, "R5");
    wr(1'b1, 8'h02);
    rd_expect(1'b1, 8'h02, "R5");
    port_pins[1] = 1'b1; step(5);
    rd_expect(1'b0, 8'h81, "R5");
    wr(1'b0, 8'h89);
    chk_irq(1'b1, "R8");
    step(4);
    rd_expect(1'b0, 8'h89, "R6");
    wr(1'b0, 8'h88);
    chk_irq(1'b0, "R6");
    // R7 set beats clear in the same cycle
    wr(1'b0, 8'h84);
    bus_addr = 1'b0; bus_wdata = 8'h80; bus_we = 1'b1; tmr_wrap = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tmr_wrap = 1'b0;
    rd_expect(1'b0, 8'h84, "R7");
    wr(1'b0, 8'h80);
    // R9 peripheral gate
    periph_req = 3'b100;
    step(1);
    chk_irq(1'b0, "R9");
    wr(1'b0, 8'hC0);
    chk_irq(1'b1, "R9");
    wr(1'b0, 8'h40);
    chk_irq(1'b0, "R8");
    periph_req = '0;
    wr(1'b0, 8'hC0);
    chk_irq(1'b0, "R9");
    step(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d reads without response, expected 0", exp_q.size());
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule